// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock for an I2C master from the system clock in two stages. A prescaler divides the core clock by a programmable amount to give a module tick. A phase counter then builds each SCL bit from a low phase and a high phase. Each phase lasts its own programmed count plus a fixed overhead of six module ticks. A full bit therefore takes (low + 6) + (high + 6) module ticks, and 12 ticks when both counts are zero.

The byte engine that sequences data uses the strobes for falling SCL, rising SCL and end of bit. It can keep SCL low with a hold request. A slave stretches the clock by keeping the line low. The high phase only counts ticks while the sampled line (`scl_in`) reads high. The prescale value and the two phase counts can be written only while the peripheral is held in soft reset. The written values apply from the moment soft reset is released. Software computes these values from the target frequencies.

Top module: `scl_clock_gen`

## Requirements
- R1: After `rst`, `scl_out` is 1 and `fall_stb`, `rise_stb` and `bit_stb` are 0.
- R2: With prescale value P, the module tick occurs once every P+1 system clocks, so every phase length in clocks is its tick count times P+1.
- R3: With low count L and high count H, SCL stays low for (L+6) ticks and high for (H+6) ticks. The interval from one falling strobe to the next is (L+H+12)·(P+1) clocks.
- R4: Low and high counts of 0 are legal and give the minimum bit of 12 ticks: 6 low and 6 high.
- R5: A configuration write (`cfg_we`) while `soft_rst` is 0 is ignored, and the running timing is unchanged.
- R6: While `soft_rst` is 1, SCL is released (1) and a configuration write is stored. The new timing applies once `soft_rst` returns to 0.
- R7: While `enable` is 0 and no bit is in progress, SCL stays 1. Deasserting `enable` lets the current bit finish. A new bit always begins with the low phase.
- R8: The high phase counts ticks only while `scl_in` is 1. With prescale 0, a slave holding SCL low for S clocks after the rise lengthens the high phase to H+6+S clocks.
- R9: While `hold_low` is 1 at the end of the low phase, SCL stays low. With prescale 0, the rise happens on the first tick after `hold_low` returns to 0.
- R10: `fall_stb` and `rise_stb` are single-clock pulses, asserted in the cycle in which `scl_out` changes, and never both at once. `bit_stb` pulses at the end of every high phase, together with the next fall if one follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; clears configuration |
| soft_rst | input | 1 | Peripheral held in reset; allows configuration writes and idles SCL |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_prescale | input | 8 | Prescale value P (tick = clk/(P+1)) |
| cfg_low | input | 16 | Low-phase count L |
| cfg_high | input | 16 | High-phase count H |
| enable | input | 1 | Run bits back to back while 1 |
| hold_low | input | 1 | Byte engine request to keep SCL low |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_out | output | 1 | SCL drive level (0 = pull low, 1 = release) |
| fall_stb | output | 1 | Pulse in the cycle SCL goes low |
| rise_stb | output | 1 | Pulse in the cycle SCL is released |
| bit_stb | output | 1 | Pulse at the end of each bit |

## Verification
The assertions assume that `scl_in` is never high while the block drives SCL low. This holds because the line is wired-AND, and the bench models it as `scl_out` ANDed with a stretch flag. They also assume that configuration changes only arrive through `cfg_we` during soft reset. The bench changes every input just after a falling clock edge and samples outputs at that edge. It uses prescale 0 for the stretch and hold tests, so the exact lengths it expects follow directly from the requirements.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    localparam int unsigned PRESCALE_W     = 8;
    localparam int unsigned PHASE_W        = 16;
    localparam int unsigned PHASE_CNT_W    = PHASE_W + 1;
    localparam int unsigned PHASE_OVERHEAD = 6;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [PRESCALE_W-1:0] prescale;
        logic [PHASE_W-1:0]    low_cnt;
        logic [PHASE_W-1:0]    high_cnt;
    } timing_cfg_t;

    typedef struct packed {
        logic level;
        logic fall;
        logic rise;
        logic bit_end;
    } scl_evt_t;

    localparam scl_evt_t EVT_IDLE = '{level: 1'b1, fall: 1'b0, rise: 1'b0, bit_end: 1'b0};

    // Index of the last tick of a phase programmed with count c.
    function automatic logic [PHASE_CNT_W-1:0] phase_last(input logic [PHASE_W-1:0] c);
        return {1'b0, c} + PHASE_CNT_W'(PHASE_OVERHEAD - 1);
    endfunction

endpackage

// File: rtl/sclgen_cfg_regs.sv
module sclgen_cfg_regs
    import sclgen_pkg::*;
#(
    parameter timing_cfg_t RESET_CFG = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        we,
    input  timing_cfg_t wr_cfg,
    output timing_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= RESET_CFG;
        end else if (we && soft_rst) begin
            cfg <= wr_cfg;
        end
    end

    // Configuration only moves when the previous cycle was in soft reset.
    a_r5_frozen_when_running: assert property (@(posedge clk) disable iff (rst)
        !$past(soft_rst) |-> $stable(cfg))
        else $error("configuration changed outside soft reset");

endmodule

// File: rtl/sclgen_prescaler.sv
module sclgen_prescaler
    import sclgen_pkg::*;
#(
    parameter int unsigned W = PRESCALE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] prescale,
    output logic         tick
);

    logic [W-1:0] div_cnt;

    assign tick = run && (div_cnt == prescale);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt <= '0;
        end else if (div_cnt == prescale) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + W'(1);
        end
    end

    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst || !run)
        div_cnt <= prescale)
        else $error("prescale counter beyond terminal");

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst || !run)
        (tick && prescale != '0) |=> !tick)
        else $error("ticks closer than prescale allows");

endmodule

// File: rtl/sclgen_phase_fsm.sv
module sclgen_phase_fsm
    import sclgen_pkg::*;
#(
    parameter int unsigned PW = PHASE_W,
    localparam int unsigned CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          enable,
    input  logic          hold_low,
    input  logic          scl_in,
    input  logic          tick,
    input  logic [PW-1:0] low_cnt,
    input  logic [PW-1:0] high_cnt,
    output scl_evt_t      evt
);

    phase_e        state;
    logic [CW-1:0] ph_cnt;
    logic [CW-1:0] low_last;
    logic [CW-1:0] high_last;
    logic          low_done;
    logic          high_done;

    assign low_last  = phase_last(low_cnt);
    assign high_last = phase_last(high_cnt);
    assign low_done  = tick && (ph_cnt >= low_last);
    assign high_done = tick && scl_in && (ph_cnt >= high_last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state  <= PH_IDLE;
            ph_cnt <= '0;
            evt    <= EVT_IDLE;
        end else begin
            evt.fall    <= 1'b0;
            evt.rise    <= 1'b0;
            evt.bit_end <= 1'b0;
            unique case (state)
                PH_IDLE: begin
                    if (enable && tick) begin
                        state     <= PH_LOW;
                        ph_cnt    <= '0;
                        evt.level <= 1'b0;
                        evt.fall  <= 1'b1;
                    end
                end
                PH_LOW: begin
                    if (low_done) begin
                        if (!hold_low) begin
                            state     <= PH_HIGH;
                            ph_cnt    <= '0;
                            evt.level <= 1'b1;
                            evt.rise  <= 1'b1;
                        end
                    end else if (tick) begin
                        ph_cnt <= ph_cnt + CW'(1);
                    end
                end
                PH_HIGH: begin
                    if (high_done) begin
                        evt.bit_end <= 1'b1;
                        ph_cnt      <= '0;
                        if (enable) begin
                            state     <= PH_LOW;
                            evt.level <= 1'b0;
                            evt.fall  <= 1'b1;
                        end else begin
                            state <= PH_IDLE;
                        end
                    end else if (tick && scl_in) begin
                        ph_cnt <= ph_cnt + CW'(1);
                    end
                end
                default: begin
                    state     <= PH_IDLE;
                    evt.level <= 1'b1;
                end
            endcase
        end
    end

    a_r10_edges_exclusive: assert property (@(posedge clk) disable iff (rst || !run)
        !(evt.fall && evt.rise))
        else $error("fall and rise strobes together");

    a_r10_fall_on_change: assert property (@(posedge clk) disable iff (rst || !run)
        evt.fall |-> $fell(evt.level))
        else $error("fall strobe without SCL falling");

    a_r10_rise_on_change: assert property (@(posedge clk) disable iff (rst || !run)
        evt.rise |-> $rose(evt.level))
        else $error("rise strobe without SCL rising");

    a_r7_idle_released: assert property (@(posedge clk) disable iff (rst || !run)
        (state == PH_IDLE) |-> evt.level)
        else $error("SCL driven low while idle");

    a_r3_low_count_bound: assert property (@(posedge clk) disable iff (rst || !run)
        (state == PH_LOW) |-> (ph_cnt <= low_last))
        else $error("low phase counter overran");

    a_r8_high_waits_line: assert property (@(posedge clk) disable iff (rst || !run)
        (state == PH_HIGH && !scl_in) |=> $stable(ph_cnt))
        else $error("high phase counted while line low");

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import sclgen_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_rst,
    input  logic                  cfg_we,
    input  logic [PRESCALE_W-1:0] cfg_prescale,
    input  logic [PHASE_W-1:0]    cfg_low,
    input  logic [PHASE_W-1:0]    cfg_high,
    input  logic                  enable,
    input  logic                  hold_low,
    input  logic                  scl_in,
    output logic                  scl_out,
    output logic                  fall_stb,
    output logic                  rise_stb,
    output logic                  bit_stb
);

    timing_cfg_t wr_cfg;
    timing_cfg_t cfg;
    scl_evt_t    evt;
    logic        tick;
    logic        run;

    assign run    = !soft_rst;
    assign wr_cfg = '{prescale: cfg_prescale, low_cnt: cfg_low, high_cnt: cfg_high};

    sclgen_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .we       (cfg_we),
        .wr_cfg   (wr_cfg),
        .cfg      (cfg)
    );

    sclgen_prescaler #(.W(PRESCALE_W)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .prescale (cfg.prescale),
        .tick     (tick)
    );

    sclgen_phase_fsm #(.PW(PHASE_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .enable   (enable),
        .hold_low (hold_low),
        .scl_in   (scl_in),
        .tick     (tick),
        .low_cnt  (cfg.low_cnt),
        .high_cnt (cfg.high_cnt),
        .evt      (evt)
    );

    assign scl_out  = evt.level;
    assign fall_stb = evt.fall;
    assign rise_stb = evt.rise;
    assign bit_stb  = evt.bit_end;

    a_r6_soft_reset_releases: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst) |-> scl_out)
        else $error("SCL low after soft reset");

endmodule

// File: tb/scl_clock_gen_tb_top.sv
module scl_clock_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst, soft_rst, cfg_we, enable, hold_low, stretch;
    logic [7:0]  cfg_prescale;
    logic [15:0] cfg_low, cfg_high;
    logic        scl_in, scl_out, fall_stb, rise_stb, bit_stb;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    assign scl_in = scl_out & ~stretch;

    scl_clock_gen dut_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_we(cfg_we),
        .cfg_prescale(cfg_prescale), .cfg_low(cfg_low), .cfg_high(cfg_high),
        .enable(enable), .hold_low(hold_low), .scl_in(scl_in),
        .scl_out(scl_out), .fall_stb(fall_stb), .rise_stb(rise_stb), .bit_stb(bit_stb)
    );

    // {prescale, low, high}
    localparam int NVEC = 5;
    localparam logic [39:0] VEC [NVEC] = '{
        {8'd0, 16'd0,  16'd0},
        {8'd1, 16'd2,  16'd2},
        {8'd3, 16'd0,  16'd5},
        {8'd2, 16'd10, 16'd4},
        {8'd0, 16'd20, 16'd20}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts falling clock edges until the chosen strobe is seen (0 fall, 1 rise, 2 bit).
    task automatic wait_ev(input int sel, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if ((sel == 0 && fall_stb) || (sel == 1 && rise_stb) || (sel == 2 && bit_stb)) break;
            if (n > 20000) begin n = -1; break; end
        end
    endtask

    task automatic apply_cfg(input int p, input int l, input int h);
        @(negedge clk);
        soft_rst = 1'b1; enable = 1'b0; cfg_we = 1'b1;
        cfg_prescale = 8'(p); cfg_low = 16'(l); cfg_high = 16'(h);
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        soft_rst = 1'b0; enable = 1'b1;
    endtask

    function automatic string pick_req(input int idx);
        return (idx == 0) ? "R4" : "R3";
    endfunction

    initial begin
        int n;
        rst = 1'b1; soft_rst = 1'b1; cfg_we = 1'b0; enable = 1'b0;
        hold_low = 1'b0; stretch = 1'b0;
        cfg_prescale = '0; cfg_low = '0; cfg_high = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 scl", int'(scl_out), 1);
        check("R1 strobes", int'({fall_stb, rise_stb, bit_stb}), 0);

        for (int i = 0; i < NVEC; i++) begin
            int p, l, h, tl, th;
            p = int'(VEC[i][39:32]); l = int'(VEC[i][31:16]); h = int'(VEC[i][15:0]);
            tl = (l + 6) * (p + 1);
            th = (h + 6) * (p + 1);
            apply_cfg(p, l, h);
            wait_ev(0, n);
            wait_ev(1, n);
            check(pick_req(i), n, tl);
            wait_ev(0, n);
            check(pick_req(i), n, th);
            check("R10 bit strobe with fall", int'(bit_stb), 1);
            wait_ev(0, n);
            check("R2 period", n, (l + h + 12) * (p + 1));
        end

        // R10: strobe lasts one clock, SCL held low after it
        @(negedge clk);
        check("R10 single pulse", int'(fall_stb), 0);
        check("R10 level", int'(scl_out), 0);

        // R5: write while running is ignored
        apply_cfg(0, 4, 4);
        wait_ev(0, n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_prescale = 8'd3; cfg_low = 16'd30; cfg_high = 16'd30;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_ev(0, n);
        wait_ev(1, n);
        check("R5 low", n, 10);
        wait_ev(0, n);
        check("R5 high", n, 10);

        // R9: hold low for 3 extra clocks past the nominal end
        begin
            int k;
            k = 0;
            hold_low = 1'b1;
            do begin
                @(negedge clk);
                k++;
                if (k == 13) hold_low = 1'b0;
            end while (!rise_stb && k < 1000);
            check("R9 held low", k, 14);
        end

        // R8: slave stretches high phase by 5 clocks
        begin
            int k;
            k = 0;
            stretch = 1'b1;
            do begin
                @(negedge clk);
                k++;
                if (k == 5) stretch = 1'b0;
            end while (!fall_stb && k < 1000);
            check("R8 stretched high", k, 15);
        end

        // R6: soft reset releases SCL, new timing after release
        @(negedge clk);
        check("R6 low before soft reset", int'(scl_out), 0);
        soft_rst = 1'b1; cfg_we = 1'b1;
        cfg_prescale = 8'd1; cfg_low = 16'd1; cfg_high = 16'd3;
        @(negedge clk);
        check("R6 released in soft reset", int'(scl_out), 1);
        cfg_we = 1'b0;
        @(negedge clk);
        soft_rst = 1'b0;
        wait_ev(0, n);
        wait_ev(1, n);
        check("R6 new low", n, 14);
        wait_ev(0, n);
        check("R6 new high", n, 18);

        // R7: disable mid-bit finishes the bit then idles high
        enable = 1'b0;
        wait_ev(2, n);
        check("R7 no fall at last bit end", int'(fall_stb), 0);
        begin
            int low_seen;
            low_seen = 0;
            repeat (60) begin
                @(negedge clk);
                if (!scl_out || fall_stb) low_seen++;
            end
            check("R7 idle high", low_seen, 0);
        end
        enable = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!fall_stb && !rise_stb && n < 1000);
        check("R7 starts with low", int'(fall_stb), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule